// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM's contents alive and brings the device up correctly. After reset it holds the strobes idle for a programmable power-up pause, counted in clock cycles. It then runs a fixed number of warm-up refresh cycles on its own, with no handshake. After the last warm-up cycle has finished its RAS precharge, it raises `init_done`, and normal accesses may begin.

From then on an interval timer adds one pending refresh per refresh interval. While any refresh is pending, the sequencer requests the bus from the access controller. When the controller grants it, the sequencer drives complete refresh cycles on RAS, both CAS strobes, the 9-bit address and WE/OE. Pending refreshes accumulate up to a limit while the controller is busy. At that limit the request turns urgent, and the controller is expected to close any open page and grant the bus.

Two refresh styles are supported. CAS-before-RAS cycles rely on the device's internal row counter. RAS-only cycles present the sequencer's own row counter on the address pins. The style is sampled at the start of each cycle.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, RAS and both CAS strobes are high (inactive) and `init_done`, `rfsh_req`, `rfsh_urgent` and `bus_own` are low.
- R2: RAS does not fall during the first PAUSE_CYC clock cycles after reset is released, and the strobes stay high throughout the pause.
- R3: Exactly WARMUP_CNT refresh cycles run after the pause without any grant. `init_done` rises only after the last of them, once RAS has been high for at least T_RP cycles. With `ras_only_mode` low, every warm-up cycle is CAS-before-RAS.
- R4: In a CAS-before-RAS cycle (`ras_only_mode`=0 at start), both CAS strobes fall together at least T_CSR cycles before RAS falls. They stay low for exactly the first T_CHR cycles of the RAS-low period and are high again before RAS rises.
- R5: In a RAS-only cycle (`ras_only_mode`=1 at start), both CAS strobes stay high. The address holds the internal row counter when RAS falls. The counter starts at 0 after reset, advances by one after each RAS-only cycle, wraps from 511 to 0, and does not move on CAS-before-RAS cycles.
- R6: Every refresh RAS-low pulse lasts exactly T_RAS cycles. Between two refresh pulses, RAS stays high for at least T_RP cycles.
- R7: After `init_done`, one refresh becomes pending every INTERVAL_CYC cycles. `rfsh_req` is high exactly while at least one refresh is pending.
- R8: After `init_done`, a refresh cycle starts only in a cycle where `rfsh_gnt` is high and a refresh is pending. Each started cycle retires one pending refresh.
- R9: The pending count saturates at MAX_PEND. `rfsh_urgent` is high exactly while the count equals MAX_PEND.
- R10: When a new interval elapses in the same cycle that a refresh starts, the pending count stays as it was, and this holds at saturation too.
- R11: WE and OE are high whenever a refresh RAS pulse begins or ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_only_mode | input | 1 | 1: RAS-only refresh with internal row counter; 0: CAS-before-RAS |
| rfsh_gnt | input | 1 | Bus grant from the access controller |
| rfsh_req | output | 1 | At least one refresh pending |
| rfsh_urgent | output | 1 | Pending count at its limit |
| init_done | output | 1 | Power-up sequence complete |
| bus_own | output | 1 | Sequencer is driving the DRAM pins |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| addr | output | ROW_W | Row address for RAS-only refresh |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The interval timer can add a pending refresh in the same edge where a grant retires one. This matters most once the count is saturated. The bench aligns to the edge where a refresh first becomes pending. It then waits until the count has reached its limit and raises the grant so that the first start lands exactly on the next interval edge. It judges the result by counting RAS pulses until the request drops: one more than the limit shows that the new interval was kept, not lost to saturation.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_SETUP,
        CYC_RASLO,
        CYC_PRECH
    } cyc_state_e;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WARM,
        PH_RUN
    } phase_e;

endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = en && (tmr_q.cnt == CW'(LIMIT - 1));
        if (!en || tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= CW'(LIMIT - 1)); // R7

endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic pend_nz,
    output logic pend_full
);
    localparam int PW = $clog2(MAX_PEND + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d    = pend_q;
        pend_nz   = (pend_q.cnt != '0);
        pend_full = (pend_q.cnt == PW'(MAX_PEND));
        unique case ({inc, dec})
            2'b10:   if (!pend_full) pend_d.cnt = pend_q.cnt + 1'b1;
            2'b01:   if (pend_nz)    pend_d.cnt = pend_q.cnt - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q.cnt <= PW'(MAX_PEND)); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> pend_nz); // R8
    AST_PEND_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(pend_q.cnt)); // R10

endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int ROW_W = 9,
    parameter int T_CSR = 1,
    parameter int T_CHR = 1,
    parameter int T_RAS = 4,
    parameter int T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ras_only,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row,
    output logic             busy,
    output logic             done
);
    localparam int MAXT_A = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int MAXT   = (MAXT_A > T_RP) ? MAXT_A : T_RP;
    localparam int CW     = $clog2(MAXT + 1);
    localparam int CAS_REL = T_RAS - 1 - T_CHR;

    typedef struct packed {
        cyc_state_e       state;
        logic [CW-1:0]    cnt;
        logic             mode;
        logic             ras_n;
        logic             cas_n;
        logic [ROW_W-1:0] row;
    } cyc_t;

    cyc_t cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_q;
        unique case (cyc_q.state)
            CYC_IDLE: begin
                if (start) begin
                    cyc_d.state = CYC_SETUP;
                    cyc_d.cnt   = CW'(T_CSR - 1);
                    cyc_d.mode  = ras_only;
                end
            end
            CYC_SETUP: begin
                if (cyc_q.cnt == '0) begin
                    cyc_d.state = CYC_RASLO;
                    cyc_d.cnt   = CW'(T_RAS - 1);
                end else begin
                    cyc_d.cnt = cyc_q.cnt - 1'b1;
                end
            end
            CYC_RASLO: begin
                if (cyc_q.cnt == '0) begin
                    cyc_d.state = CYC_PRECH;
                    cyc_d.cnt   = CW'(T_RP - 1);
                end else begin
                    cyc_d.cnt = cyc_q.cnt - 1'b1;
                end
            end
            CYC_PRECH: begin
                if (cyc_q.cnt == '0) begin
                    cyc_d.state = CYC_IDLE;
                    if (cyc_q.mode) cyc_d.row = cyc_q.row + 1'b1;
                end else begin
                    cyc_d.cnt = cyc_q.cnt - 1'b1;
                end
            end
            default: cyc_d.state = CYC_IDLE;
        endcase
        cyc_d.ras_n = (cyc_d.state != CYC_RASLO);
        cyc_d.cas_n = !(!cyc_d.mode &&
                        ((cyc_d.state == CYC_SETUP) ||
                         ((cyc_d.state == CYC_RASLO) && (cyc_d.cnt > CW'(CAS_REL)))));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q       <= '0;
            cyc_q.state <= CYC_IDLE;
            cyc_q.ras_n <= 1'b1;
            cyc_q.cas_n <= 1'b1;
        end else begin
            cyc_q <= cyc_d;
        end
    end

    assign ras_n = cyc_q.ras_n;
    assign cas_n = cyc_q.cas_n;
    assign row   = cyc_q.row;
    assign busy  = (cyc_q.state != CYC_IDLE);
    assign done  = (cyc_q.state == CYC_PRECH) && (cyc_q.cnt == '0);

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cyc_q.ras_n) && !cyc_q.mode) |-> (!cyc_q.cas_n && $past(!cyc_q.cas_n))); // R4
    AST_CAS_UP_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_q.ras_n) |-> $past(cyc_q.cas_n)); // R4
    AST_RAS_ONLY_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_q.ras_n && cyc_q.mode) |-> cyc_q.cas_n); // R5
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cyc_q.mode) |=> (cyc_q.row == ROW_W'($past(cyc_q.row) + 1'b1))); // R5
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cyc_q.mode) |=> $stable(cyc_q.row)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cyc_q.ras_n && cyc_q.cas_n)); // R6

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int WARMUP_CNT   = 8,
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_PEND     = 8,
    parameter int ROW_W        = 9,
    parameter int T_CSR        = 1,
    parameter int T_CHR        = 1,
    parameter int T_RAS        = 4,
    parameter int T_RP         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_only_mode,
    input  logic             rfsh_gnt,
    output logic             rfsh_req,
    output logic             rfsh_urgent,
    output logic             init_done,
    output logic             bus_own,
    output logic             ras_n,
    output logic             lcas_n,
    output logic             ucas_n,
    output logic [ROW_W-1:0] addr,
    output logic             we_n,
    output logic             oe_n
);
    localparam int WW = $clog2(WARMUP_CNT + 1);

    typedef struct packed {
        phase_e        phase;
        logic [WW-1:0] warm_cnt;
        logic          init_done;
    } top_t;

    top_t top_d, top_q;

    logic pause_tick, ival_tick;
    logic pend_nz, pend_full;
    logic cyc_start, cyc_busy, cyc_done, cyc_cas_n;
    logic run_start;

    rfsh_tick_timer #(.LIMIT(PAUSE_CYC)) i_pause_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (top_q.phase == PH_PAUSE),
        .tick (pause_tick)
    );

    rfsh_tick_timer #(.LIMIT(INTERVAL_CYC)) i_ival_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (top_q.phase == PH_RUN),
        .tick (ival_tick)
    );

    rfsh_pend_ctr #(.MAX_PEND(MAX_PEND)) i_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (ival_tick),
        .dec      (run_start),
        .pend_nz  (pend_nz),
        .pend_full(pend_full)
    );

    rfsh_cycle_fsm #(
        .ROW_W(ROW_W), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
    ) i_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cyc_start),
        .ras_only(ras_only_mode),
        .ras_n   (ras_n),
        .cas_n   (cyc_cas_n),
        .row     (addr),
        .busy    (cyc_busy),
        .done    (cyc_done)
    );

    always_comb begin
        top_d     = top_q;
        run_start = (top_q.phase == PH_RUN) && !cyc_busy && rfsh_gnt && pend_nz;
        cyc_start = run_start || ((top_q.phase == PH_WARM) && !cyc_busy);
        unique case (top_q.phase)
            PH_PAUSE: if (pause_tick) top_d.phase = PH_WARM;
            PH_WARM: begin
                if (cyc_done) begin
                    if (top_q.warm_cnt == WW'(WARMUP_CNT - 1)) begin
                        top_d.phase     = PH_RUN;
                        top_d.init_done = 1'b1;
                    end else begin
                        top_d.warm_cnt = top_q.warm_cnt + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q       <= '0;
            top_q.phase <= PH_PAUSE;
        end else begin
            top_q <= top_d;
        end
    end

    assign init_done   = top_q.init_done;
    assign rfsh_req    = pend_nz;
    assign rfsh_urgent = pend_full;
    assign bus_own     = (top_q.phase == PH_WARM) || cyc_busy;
    assign lcas_n      = cyc_cas_n;
    assign ucas_n      = cyc_cas_n;
    assign we_n        = 1'b1;
    assign oe_n        = 1'b1;

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.phase == PH_PAUSE) |-> (ras_n && lcas_n && ucas_n && !bus_own)); // R2
    AST_INIT_AFTER_PRECH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(cyc_done) && ras_n)); // R3
    AST_NO_GRANTLESS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !cyc_busy && !rfsh_gnt) |=> !cyc_busy); // R8
    AST_REQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req && !run_start) |=> rfsh_req); // R7
    AST_URGENT_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_urgent |-> rfsh_req); // R9

endmodule

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;
    localparam int PAUSE    = 50;
    localparam int WARM     = 8;
    localparam int INTERVAL = 100;
    localparam int MAXP     = 4;
    localparam int ROWW     = 9;
    localparam int TCSR     = 2;
    localparam int TCHR     = 2;
    localparam int TRAS     = 6;
    localparam int TRP      = 4;

    // {mode, intervals waited, expected RAS pulses after grant}
    localparam int NVEC = 5;
    localparam int TBL [NVEC][3] = '{
        '{0, 1, 1}, '{1, 2, 2}, '{0, 3, 3}, '{1, 4, 4}, '{0, 6, 4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_only_mode = 1'b0;
    logic rfsh_gnt = 1'b0;
    logic rfsh_req, rfsh_urgent, init_done, bus_own;
    logic ras_n, lcas_n, ucas_n, we_n, oe_n;
    logic [ROWW-1:0] addr;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC(PAUSE), .WARMUP_CNT(WARM), .INTERVAL_CYC(INTERVAL),
        .MAX_PEND(MAXP), .ROW_W(ROWW), .T_CSR(TCSR), .T_CHR(TCHR),
        .T_RAS(TRAS), .T_RP(TRP)
    ) i_dram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .ras_only_mode(ras_only_mode),
        .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req), .rfsh_urgent(rfsh_urgent),
        .init_done(init_done), .bus_own(bus_own), .ras_n(ras_n),
        .lcas_n(lcas_n), .ucas_n(ucas_n), .addr(addr), .we_n(we_n), .oe_n(oe_n)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // pin monitor
    bit allow = 0;
    int cyc, fall_cnt, warm_falls, exp_row, last_row;
    int ras_low_run, ras_high_run, cas_low_run, cas_in_ras;
    bit ras_prev, init_prev, had_pulse, wrap_seen;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; fall_cnt = 0; warm_falls = 0; exp_row = 0; last_row = -1;
            ras_low_run = 0; ras_high_run = 0; cas_low_run = 0; cas_in_ras = 0;
            ras_prev = 1; init_prev = 0; had_pulse = 0; wrap_seen = 0;
        end else begin
            cyc++;
            if (ras_prev && !ras_n) begin
                fall_cnt++;
                if (!init_done) warm_falls++;
                if (!had_pulse) chk(cyc >= PAUSE, "R2 first RAS fall cycle", cyc, PAUSE);
                else chk(ras_high_run >= TRP, "R6 precharge", ras_high_run, TRP);
                chk(init_done == 0 || allow, "R8 refresh without grant", 1, 0);
                chk(we_n && oe_n, "R11 WE/OE at RAS fall", {we_n, oe_n}, 3);
                chk(lcas_n == ucas_n, "R4 CAS strobes together", {lcas_n, ucas_n}, 0);
                if (!ras_only_mode) begin
                    chk(!lcas_n && cas_low_run >= TCSR, "R4 CAS setup", cas_low_run, TCSR);
                end else begin
                    chk(lcas_n && ucas_n, "R5 CAS high in RAS-only", {lcas_n, ucas_n}, 3);
                    chk(int'(addr) == exp_row, "R5 row address", addr, exp_row);
                    if (last_row == 511 && addr == 0) wrap_seen = 1;
                    last_row = addr;
                    exp_row = (exp_row + 1) % 512;
                end
                had_pulse = 1;
                cas_in_ras = 0;
            end
            if (!ras_prev && ras_n) begin
                chk(ras_low_run == TRAS, "R6 RAS pulse width", ras_low_run, TRAS);
                chk(we_n && oe_n, "R11 WE/OE at RAS rise", {we_n, oe_n}, 3);
                chk(lcas_n && ucas_n, "R4 CAS high at RAS rise", {lcas_n, ucas_n}, 3);
                if (!ras_only_mode) chk(cas_in_ras == TCHR, "R4 CAS hold", cas_in_ras, TCHR);
            end
            if (init_done && !init_prev) begin
                chk(warm_falls == WARM, "R3 warm-up count", warm_falls, WARM);
                chk(ras_n && ras_high_run >= TRP, "R3 init after precharge", ras_high_run, TRP);
            end
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            cas_low_run  = lcas_n ? 0 : cas_low_run + 1;
            if (!ras_n && !lcas_n) cas_in_ras++;
            ras_prev  = ras_n;
            init_prev = init_done;
        end
    end

    task automatic sync_req();
        while (!rfsh_req) @(negedge clk);
    endtask

    task automatic serve(input int exp, input string rq);
        int f0;
        f0 = fall_cnt;
        allow = 1;
        rfsh_gnt = 1'b1;
        repeat (80) @(negedge clk);
        rfsh_gnt = 1'b0;
        while (bus_own) @(negedge clk);
        allow = 0;
        chk(fall_cnt - f0 == exp, rq, fall_cnt - f0, exp);
        chk(!rfsh_req, "R7 request drops when drained", rfsh_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(ras_n && lcas_n && ucas_n, "R1 strobes in reset", {ras_n, lcas_n, ucas_n}, 7);
        chk(!init_done && !rfsh_req && !rfsh_urgent && !bus_own, "R1 flags in reset",
            {init_done, rfsh_req, rfsh_urgent, bus_own}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && !bus_own && !init_done, "R1 state after reset", {ras_n, bus_own, init_done}, 4);
        repeat (PAUSE - 5) @(negedge clk);
        chk(ras_n && lcas_n && !bus_own, "R2 quiet during pause", {ras_n, lcas_n, bus_own}, 6);
        while (!init_done) @(negedge clk);
        chk(!rfsh_req, "R7 nothing pending at init", rfsh_req, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            ras_only_mode = TBL[i][0][0];
            sync_req();
            repeat ((TBL[i][1] - 1) * INTERVAL + 10) @(negedge clk);
            chk(rfsh_req, "R7 request pending", rfsh_req, 1);
            chk(rfsh_urgent == (TBL[i][1] >= MAXP), "R9 urgent level", rfsh_urgent,
                int'(TBL[i][1] >= MAXP));
            serve(TBL[i][2], "R9 pulses served");
        end

        // exact interval spacing and urgent edge
        ras_only_mode = 1'b0;
        sync_req();
        repeat (3 * INTERVAL - 1) @(negedge clk);
        chk(!rfsh_urgent, "R7 interval spacing before limit", rfsh_urgent, 0);
        @(negedge clk);
        chk(rfsh_urgent, "R9 urgent at limit", rfsh_urgent, 1);
        serve(MAXP, "R8 one pulse per pending");

        // interval tick and start on the same edge at saturation
        sync_req();
        repeat (4 * INTERVAL - 1) @(negedge clk);
        chk(rfsh_urgent, "R10 saturated before grant", rfsh_urgent, 1);
        serve(MAXP + 1, "R10 coincident tick kept");

        // row counter wrap in RAS-only mode
        ras_only_mode = 1'b1;
        allow = 1;
        rfsh_gnt = 1'b1;
        for (int k = 0; k < 60000 && !wrap_seen; k++) @(negedge clk);
        rfsh_gnt = 1'b0;
        while (bus_own) @(negedge clk);
        allow = 0;
        chk(wrap_seen, "R5 row wraps 511 to 0", wrap_seen, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule